// File: doc/BRIEF.md
# Set-Associative Tag Lookup with Timer-Aged Replacement

This block holds the tag, valid and recency state of a small set-associative cache and answers two questions every cycle for the set selected by the request index. The first is whether any way of that set holds the requested tag. The second is which way should be overwritten if the caller must bring a new line in. Each way also keeps one data word, so a hit returns that word in the same cycle. Tag, valid and recency state sit in flops, so both answers are combinational from the request inputs.

Replacement does not keep an exact least-recently-used order. Each way has a recency counter of one or two bits. A use loads the counter with its maximum value. A free-running timer ticks at a fixed period, and on each tick every counter of every set moves one step toward zero. On a miss, the caller reads the suggested victim and writes the new line through the fill port. The fill port sets the valid bit, the tag, the data word and the recency counter of the chosen way.

Top module: `setassoc_lookup`

## Requirements
- R1: A reset clears every valid bit and every recency counter. After reset, every lookup reports a miss and the suggested victim is way 0.
- R2: When a valid way of the indexed set stores the requested tag, `hit` is 1 in the same cycle, `hit_way` gives that way's number and `hit_data` gives that way's stored word.
- R3: When no valid way of the indexed set stores the requested tag, `hit` is 0.
- R4: A fill writes the tag and the data word of the addressed way, sets its valid bit and loads its recency counter with 2^AGE_W-1. The new line is visible to lookups from the next cycle.
- R5: A lookup with `req_vld` at 1 that hits loads the hit way's recency counter with 2^AGE_W-1 at the clock edge.
- R6: A tick happens at the TICK_PERIOD-th rising edge after reset is released and every TICK_PERIOD edges after that. On a tick, every non-zero recency counter of every set and way drops by one. With AGE_W=1, this clears the counter.
- R7: When an access or a fill reaches a way on a tick edge, that way's counter ends at 2^AGE_W-1 and is not decremented.
- R8: If the indexed set has any invalid way, the suggested victim is the lowest-numbered invalid way.
- R9: If all ways of the indexed set are valid, the suggested victim is the way with the smallest recency value, and ties go to the lowest-numbered way. A way at zero therefore wins whenever one exists.
- R10: A lookup with `req_vld` at 0 still reports hit, way, data and victim, but it changes no recency counter.
- R11: An access or a fill changes the state of the addressed way only. Every other set and way keeps its valid bit and tag, and its counter moves only by ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | 1 | Lookup counts as an access (updates recency on hit) |
| req_idx | input | $clog2(SETS) | Set selected for lookup and victim choice |
| req_tag | input | TAG_W | Tag compared against the set |
| fill_vld | input | 1 | Write a line this cycle |
| fill_idx | input | $clog2(SETS) | Set written by the fill |
| fill_way | input | $clog2(WAYS) | Way written by the fill |
| fill_tag | input | TAG_W | Tag stored by the fill |
| fill_data | input | DATA_W | Data word stored by the fill |
| hit | output | 1 | A valid way of the set matches the tag |
| hit_way | output | $clog2(WAYS) | Number of the matching way |
| hit_data | output | DATA_W | Data word of the matching way |
| victim_way | output | $clog2(WAYS) | Way suggested for replacement in the indexed set |

## Verification
The assertions check the following on every cycle:
- reset empties the valid state;
- a reported hit names a valid way whose stored tag equals the request;
- a fill leaves its way valid, tagged and at full recency;
- every counter either loads its maximum, decays by one on a tick, or holds;
- ticks never come back to back;
- the victim is never a valid way while an invalid one exists, and never has a larger recency value than another way of a full set.

Other behaviours show only through the bench's scenarios, which compare against a model built from the requirements:
- the exact tick period measured from reset release;
- lowest-index tie-breaking;
- an access overriding a tick on the same edge;
- the absence of updates from lookups with `req_vld` low;
- the isolation of the other sets.

// File: rtl/sac_pkg.sv
// Package: shared helpers for the set-associative lookup block.
// Assumes: callers pass positive counts.
package sac_pkg;

    // Width of an index that addresses n items, never less than one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Largest value a recency counter of w bits can hold.
    function automatic int unsigned age_top(input int unsigned w);
        return (1 << w) - 1;
    endfunction

endpackage

// File: rtl/sac_tick_timer.sv
// Module: free-running period counter that pulses one tick every PERIOD
// cycles, first at the PERIOD-th edge after reset release.
// Assumes: PERIOD >= 2, so ticks are never adjacent.
module sac_tick_timer #(
    parameter int unsigned PERIOD = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CNT_W = sac_pkg::idx_bits(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles since reset and wrap on the tick cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // R6: ticks are isolated pulses.
    a_r6_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sac_tag_match.sv
// Module: parallel tag comparison for one set. One comparator per way,
// lowest-numbered matching way reported.
// Assumes: the caller never stores one tag twice in a set.
module sac_tag_match #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 20
) (
    input  logic [WAYS-1:0][TAG_W-1:0]             way_tag,
    input  logic [WAYS-1:0]                        way_valid,
    input  logic [TAG_W-1:0]                       req_tag,
    output logic                                   hit,
    output logic [sac_pkg::idx_bits(WAYS)-1:0]     hit_way
);
    localparam int unsigned WAY_W = sac_pkg::idx_bits(WAYS);

    logic [WAYS-1:0] match;

    // One comparator per way.
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_valid[g] && (way_tag[g] == req_tag);
    end

    // Encode the lowest matching way.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/sac_victim_pick.sv
// Module: replacement choice for one set. The lowest invalid way wins;
// otherwise the way with the smallest recency wins, lowest index on ties.
// Assumes: purely combinational, inputs from the indexed set.
module sac_victim_pick #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned AGE_W = 2
) (
    input  logic [WAYS-1:0]                      way_valid,
    input  logic [WAYS-1:0][AGE_W-1:0]           way_age,
    output logic [sac_pkg::idx_bits(WAYS)-1:0]   victim
);
    localparam int unsigned WAY_W = sac_pkg::idx_bits(WAYS);

    logic             any_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] old_way;

    // Find the lowest invalid way.
    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    // Find the lowest-indexed way holding the minimum recency value.
    always_comb begin
        old_way = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (way_age[w] < way_age[old_way]) old_way = WAY_W'(w);
        end
    end

    assign victim = any_free ? free_way : old_way;

endmodule

// File: rtl/sac_age_array.sv
// Module: recency counters for every set and way. A use or fill loads the
// maximum; a tick moves every other non-zero counter down by one.
// Assumes: at most one use and one fill per cycle; the read port is combinational.
module sac_age_array #(
    parameter int unsigned SETS  = 16,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned AGE_W = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 tick,
    input  logic                                 use_vld,
    input  logic [sac_pkg::idx_bits(SETS)-1:0]   use_idx,
    input  logic [sac_pkg::idx_bits(WAYS)-1:0]   use_way,
    input  logic                                 fill_vld,
    input  logic [sac_pkg::idx_bits(SETS)-1:0]   fill_idx,
    input  logic [sac_pkg::idx_bits(WAYS)-1:0]   fill_way,
    input  logic [sac_pkg::idx_bits(SETS)-1:0]   rd_idx,
    output logic [WAYS-1:0][AGE_W-1:0]           rd_age
);
    localparam int unsigned IDX_W = sac_pkg::idx_bits(SETS);
    localparam int unsigned WAY_W = sac_pkg::idx_bits(WAYS);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(sac_pkg::age_top(AGE_W));

    logic [AGE_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]  bump  [SETS];

    // Decode which counters are refreshed this cycle.
    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                bump[s][w] = (use_vld  && use_idx  == IDX_W'(s) && use_way  == WAY_W'(w)) ||
                             (fill_vld && fill_idx == IDX_W'(s) && fill_way == WAY_W'(w));
            end
        end
    end

    // Refresh, decay or hold every counter.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (!rst_n)                         age_q[s][w] <= '0;
                else if (bump[s][w])                age_q[s][w] <= AGE_MAX;
                else if (tick && age_q[s][w] != 0)  age_q[s][w] <= age_q[s][w] - 1'b1;
            end
        end
    end

    // Read the counters of the looked-up set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) rd_age[w] = age_q[rd_idx][w];
    end

    for (genvar gs = 0; gs < SETS; gs++) begin : g_chk_set
        for (genvar gw = 0; gw < WAYS; gw++) begin : g_chk_way
            // R5/R7: a refreshed counter reads its maximum next cycle.
            a_r7_refresh_max: assert property (@(posedge clk) disable iff (!rst_n)
                bump[gs][gw] |=> age_q[gs][gw] == AGE_MAX);
            // R6: a tick lowers an untouched non-zero counter by exactly one.
            a_r6_tick_decay: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && !bump[gs][gw] && age_q[gs][gw] != 0)
                |=> age_q[gs][gw] == $past(age_q[gs][gw]) - 1'b1);
            // R11: without a tick or a refresh, a counter holds.
            a_r11_age_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!tick && !bump[gs][gw]) |=> $stable(age_q[gs][gw]));
        end
    end

endmodule

// File: rtl/setassoc_lookup.sv
// Module: top of the set-associative lookup. It holds tag, valid and data
// flops, answers hit and victim combinationally for req_idx, and updates
// state through the fill port and on accesses.
// Assumes: fills only target a way chosen by the caller; no duplicate tags in a set.
module setassoc_lookup #(
    parameter int unsigned SETS        = 16,
    parameter int unsigned WAYS        = 4,
    parameter int unsigned TAG_W       = 20,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned AGE_W       = 2,
    parameter int unsigned TICK_PERIOD = 256
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_vld,
    input  logic [sac_pkg::idx_bits(SETS)-1:0]   req_idx,
    input  logic [TAG_W-1:0]                     req_tag,
    input  logic                                 fill_vld,
    input  logic [sac_pkg::idx_bits(SETS)-1:0]   fill_idx,
    input  logic [sac_pkg::idx_bits(WAYS)-1:0]   fill_way,
    input  logic [TAG_W-1:0]                     fill_tag,
    input  logic [DATA_W-1:0]                    fill_data,
    output logic                                 hit,
    output logic [sac_pkg::idx_bits(WAYS)-1:0]   hit_way,
    output logic [DATA_W-1:0]                    hit_data,
    output logic [sac_pkg::idx_bits(WAYS)-1:0]   victim_way
);
    localparam int unsigned WAY_W = sac_pkg::idx_bits(WAYS);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(sac_pkg::age_top(AGE_W));

    logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
    logic [WAYS-1:0][DATA_W-1:0] data_q  [SETS];
    logic [WAYS-1:0]             valid_q [SETS];

    logic [WAYS-1:0][TAG_W-1:0]  set_tag;
    logic [WAYS-1:0][DATA_W-1:0] set_data;
    logic [WAYS-1:0]             set_valid;
    logic [WAYS-1:0][AGE_W-1:0]  set_age;
    logic                        tick;
    logic                        any_valid;

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (fill_vld) begin
            valid_q[fill_idx][fill_way] <= 1'b1;
        end
    end

    // Tag and data words: written only by a fill.
    always_ff @(posedge clk) begin
        if (fill_vld) begin
            tag_q[fill_idx][fill_way]  <= fill_tag;
            data_q[fill_idx][fill_way] <= fill_data;
        end
    end

    // Read out the indexed set.
    assign set_tag   = tag_q[req_idx];
    assign set_data  = data_q[req_idx];
    assign set_valid = valid_q[req_idx];

    // Summary of all valid bits, for the reset check.
    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
    end

    sac_tick_timer #(.PERIOD(TICK_PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sac_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_tag   (set_tag),
        .way_valid (set_valid),
        .req_tag   (req_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    assign hit_data = set_data[hit_way];

    sac_age_array #(.SETS(SETS), .WAYS(WAYS), .AGE_W(AGE_W)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .use_vld  (req_vld && hit),
        .use_idx  (req_idx),
        .use_way  (hit_way),
        .fill_vld (fill_vld),
        .fill_idx (fill_idx),
        .fill_way (fill_way),
        .rd_idx   (req_idx),
        .rd_age   (set_age)
    );

    sac_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_pick (
        .way_valid (set_valid),
        .way_age   (set_age),
        .victim    (victim_way)
    );

    // R1: reset leaves no valid way behind.
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> !any_valid);

    // R2: a reported hit names a valid way storing the requested tag.
    a_r2_hit_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (valid_q[req_idx][hit_way] && tag_q[req_idx][hit_way] == req_tag));

    // R4: a fill leaves its way valid, with the written tag and full recency.
    a_r4_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> (valid_q[$past(fill_idx)][$past(fill_way)] &&
                      tag_q[$past(fill_idx)][$past(fill_way)] == $past(fill_tag) &&
                      u_age.age_q[$past(fill_idx)][$past(fill_way)] == AGE_MAX));

    // R8: a valid way is never suggested while the set has an invalid one.
    a_r8_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid != '1) |-> !set_valid[victim_way]);

    // R9: in a full set, no way is more recent-free than the victim.
    for (genvar gw = 0; gw < WAYS; gw++) begin : g_chk_min
        a_r9_victim_oldest: assert property (@(posedge clk) disable iff (!rst_n)
            (set_valid == '1) |-> set_age[victim_way] <= set_age[gw]);
    end

endmodule

// File: tb/setassoc_lookup_tb.sv
module setassoc_lookup_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 4, WAYS = 4, TAG_W = 4, DATA_W = 8, AGE_W = 2, TP = 16;
    localparam int IDX_W = 2, WAY_W = 2;
    localparam int AMAX = (1 << AGE_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_vld = 1'b0;
    logic [IDX_W-1:0] req_idx = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic fill_vld = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0;
    logic [WAY_W-1:0] fill_way = '0;
    logic [TAG_W-1:0] fill_tag = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic hit;
    logic [WAY_W-1:0] hit_way, victim_way;
    logic [DATA_W-1:0] hit_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    setassoc_lookup #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W),
                      .AGE_W(AGE_W), .TICK_PERIOD(TP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_idx(req_idx), .req_tag(req_tag),
        .fill_vld(fill_vld), .fill_idx(fill_idx), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_data(fill_data), .hit(hit), .hit_way(hit_way), .hit_data(hit_data),
        .victim_way(victim_way));

    // Requirement-level model of the state.
    int m_valid [SETS][WAYS];
    int m_tag   [SETS][WAYS];
    int m_data  [SETS][WAYS];
    int m_age   [SETS][WAYS];
    int m_cnt;
    int n_chk = 0, n_fail = 0;
    string lbl_hit = "R2", lbl_vic = "R9";

    function automatic int exp_way(input int s, input int t);
        for (int w = 0; w < WAYS; w++) if (m_valid[s][w] != 0 && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic int exp_victim(input int s);
        int best;
        for (int w = 0; w < WAYS; w++) if (m_valid[s][w] == 0) return w;
        best = 0;
        for (int w = 1; w < WAYS; w++) if (m_age[s][w] < m_age[s][best]) best = w;
        return best;
    endfunction

    task automatic check(input string r, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", r, what, got, exp);
        end
    endtask

    task automatic model_edge(input int e_way);
        bit tk;
        tk = (m_cnt == TP - 1);
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin m_valid[s][w] = 0; m_age[s][w] = 0; end
            m_cnt = 0;
        end else begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    if ((req_vld && e_way == w && req_idx == s) ||
                        (fill_vld && fill_idx == s && fill_way == w)) m_age[s][w] = AMAX;
                    else if (tk && m_age[s][w] > 0) m_age[s][w]--;
                end
            if (fill_vld) begin
                m_valid[fill_idx][fill_way] = 1;
                m_tag[fill_idx][fill_way]   = fill_tag;
                m_data[fill_idx][fill_way]  = fill_data;
            end
            m_cnt = tk ? 0 : m_cnt + 1;
        end
    endtask

    // One cycle: inputs already set after a falling edge; check, then clock.
    task automatic cycle(input bit do_chk);
        int ew;
        #1;
        ew = exp_way(req_idx, req_tag);
        if (do_chk) begin
            check(lbl_hit, "hit", hit, ew >= 0);
            if (ew >= 0) begin
                check(lbl_hit, "hit_way", hit_way, ew);
                check(lbl_hit, "hit_data", hit_data, m_data[req_idx][ew]);
            end
            check(lbl_vic, "victim", victim_way, exp_victim(req_idx));
        end
        @(posedge clk);
        model_edge(ew);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_vld = 0; fill_vld = 0;
        for (int i = 0; i < 3; i++) cycle(0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_cnt = 0;
        @(negedge clk);
        do_reset();
        // R1: empty after reset, victim way 0 in every set.
        lbl_hit = "R1"; lbl_vic = "R1";
        for (int s = 0; s < SETS; s++) begin
            req_idx = IDX_W'(s); req_tag = 4'(s); req_vld = 1; cycle(1);
        end
        // R8: fill every way through the suggested victim; lookup misses (R3).
        lbl_hit = "R3"; lbl_vic = "R8";
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                req_vld = 0; req_idx = IDX_W'(s); req_tag = 4'hF;
                fill_vld = 1; fill_idx = IDX_W'(s); fill_way = WAY_W'(exp_victim(s));
                fill_tag = 4'(w * 3 + s); fill_data = 8'(16 * s + w + 100);
                cycle(1);
            end
        fill_vld = 0;
        // R4: every filled line hits with its data.
        lbl_hit = "R4"; lbl_vic = "R9";
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                req_idx = IDX_W'(s); req_tag = 4'(w * 3 + s); cycle(1);
            end
        // R6: idle while counters decay; misses stay misses (R3).
        lbl_hit = "R3"; lbl_vic = "R6";
        for (int i = 0; i < 4 * TP; i++) begin
            req_idx = IDX_W'(i % SETS); req_tag = 4'hE; cycle(1);
        end
        // R5: accessing ways 0..2 of set 1 leaves way 3 the victim.
        lbl_hit = "R2"; lbl_vic = "R5";
        for (int w = 0; w < 3; w++) begin
            req_vld = 1; req_idx = 2'd1; req_tag = 4'(w * 3 + 1); cycle(1);
        end
        // R10/R11: lookups with req_vld low, and other sets, leave set 1 alone.
        lbl_hit = "R10"; lbl_vic = "R11";
        req_vld = 0;
        for (int i = 0; i < 6; i++) begin
            req_idx = 2'd1; req_tag = 4'(3 * 3 + 1); cycle(1);
            req_idx = IDX_W'(i % SETS); req_tag = 4'(3 * 3 + (i % SETS)); cycle(1);
        end
        // R7: access and fill landing on a tick edge.
        lbl_hit = "R7"; lbl_vic = "R7";
        for (int k = 0; k < 3; k++) begin
            req_vld = 0; req_idx = 2'd2; req_tag = 4'hE;
            while (m_cnt != TP - 1) cycle(1);
            req_vld = 1; req_idx = 2'd2; req_tag = 4'(k * 3 + 2);
            fill_vld = 1; fill_idx = 2'd3; fill_way = WAY_W'(k + 1);
            fill_tag = 4'(13 + k); fill_data = 8'(200 + k);
            cycle(1);
            fill_vld = 0; req_vld = 0;
            for (int j = 0; j < SETS; j++) begin req_idx = IDX_W'(j); cycle(1); end
            req_idx = 2'd3; req_tag = 4'(13 + k); cycle(1);
        end
        // Random traffic from an empty cache.
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int ew;
            bit idle;
            idle = (i % 500) < 60;
            req_vld = idle ? 1'b0 : 1'($urandom % 2);
            req_idx = IDX_W'($urandom % SETS);
            req_tag = 4'($urandom % 6);
            ew = exp_way(req_idx, req_tag);
            lbl_hit = (ew >= 0) ? "R2" : "R3";
            lbl_vic = "R9";
            for (int w = 0; w < WAYS; w++) if (m_valid[req_idx][w] == 0) lbl_vic = "R8";
            fill_vld = 0;
            if (!idle && ew < 0 && ($urandom % 3) == 0) begin
                fill_vld = 1; fill_idx = req_idx; fill_way = WAY_W'(exp_victim(req_idx));
                fill_tag = req_tag; fill_data = 8'($urandom);
            end
            cycle(1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule